// File: doc/BRIEF.md
# Cascaded interrupt acknowledge sequencer

This block models a master and a slave legacy interrupt controller as they answer one processor interrupt acknowledge. Each controller latches rising request edges into its request register (IRR) and tracks serviced inputs in its in-service register (ISR). The master raises `intr_o` whenever a request outranks everything in service. A single `ack_req_i` from the host side is then expanded into two internal acknowledge pulses. The leading edge of the first pulse picks the winning input under fixed priority and moves it from IRR to ISR. The trailing edge of the first pulse places a 3-bit cascade code on a private bus. At the end of the second pulse the owning controller returns an 8-bit vector.

The slave's pending indication feeds the master input selected by `slave_id_i` when cascading is enabled. The external master line at that position is then disregarded. A request that vanishes before the first pulse yields the input-7 vector of the controller that should have answered, and no ISR bit is set. In automatic end-of-interrupt mode the serviced ISR bit is dropped when the vector is delivered. Otherwise it waits for an `eoi_*` pulse, which clears the highest-priority set ISR bit.

Top module: `pic_cascade_ack`

## Requirements
- R1: An `ack_req_i` sampled while idle produces exactly one `vec_vld_o` cycle. That cycle follows the (2·PULSE_CYC+GAP_CYC)-th rising edge after the sampling edge.
- R2: An IRR bit of an external line is set only by a low-to-high transition of that line. It is cleared while the line is low. A line already high during reset does not set it.
- R3: At the leading edge of the first pulse, the lowest-index IRR bit whose index is below every set ISR bit is cleared in IRR and set in ISR. Index 0 has the highest priority and index 7 the lowest.
- R4: `intr_o` is high one cycle after the sequencer is idle with a grantable master request. It is low from the cycle after the first pulse begins until the sequence ends, and low while only lower-or-equal priority requests than a set ISR bit remain.
- R5: At the trailing edge of the first pulse, `cas_act_o` goes to 1 and `cas_o` to the granted master index when that index equals `slave_id_i` with `casc_en_i`=1. Otherwise `cas_act_o` goes to 0. `cas_act_o` returns to 0 when the vector is delivered.
- R6: With cascading enabled, master input `slave_id_i` follows the slave's pending state one cycle later. The vector comes from the slave exactly when the cascade code matches `slave_id_i`.
- R7: The vector is {base bits [4:0] of the owning controller, 3-bit serviced index}.
- R8: If no grantable request exists at the first pulse, the vector is {base, 3'b111} of the owning controller, and that controller sets no ISR bit.
- R9: With `aeoi_i`=1 the serviced ISR bits are cleared at the end of the second pulse. With `aeoi_i`=0 they stay set.
- R10: A one-cycle `eoi_m_i`/`eoi_s_i` clears the lowest-index set ISR bit of that controller.
- R11: `ack_req_i` is ignored while a sequence is in progress.
- R12: After reset, all IRR and ISR bits, `intr_o`, `vec_vld_o`, `vec_o`, `cas_act_o` and `cas_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_m_i | input | N_LINES | Master request lines |
| irq_s_i | input | N_LINES | Slave request lines |
| ack_req_i | input | 1 | Host-side acknowledge request |
| eoi_m_i | input | 1 | Master end-of-interrupt pulse |
| eoi_s_i | input | 1 | Slave end-of-interrupt pulse |
| base_m_hi_i | input | VEC_W-IW | Upper vector bits of the master |
| base_s_hi_i | input | VEC_W-IW | Upper vector bits of the slave |
| casc_en_i | input | 1 | Slave attached to the master |
| slave_id_i | input | IW | Master input the slave is wired to, and the slave identity |
| aeoi_i | input | 1 | Automatic end-of-interrupt mode |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Returned vector |
| vec_vld_o | output | 1 | One-cycle vector strobe |
| cas_o | output | IW | Cascade code |
| cas_act_o | output | 1 | Cascade code addresses the slave |
| irr_m_o | output | N_LINES | Master IRR |
| isr_m_o | output | N_LINES | Master ISR |
| irr_s_o | output | N_LINES | Slave IRR |
| isr_s_o | output | N_LINES | Slave ISR |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that `casc_en_i`, `slave_id_i` and the vector bases stay steady while an acknowledge is in flight, since the cascade flag is tested against the live enable. The stimulus changes those settings only while the sequencer is idle and keeps them fixed during the randomised phase. Only request lines, end-of-interrupt pulses, the automatic mode and acknowledge requests vary there, including requests issued mid-sequence.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_P1   = 2'd1,
    SQ_GAP  = 2'd2,
    SQ_P2   = 2'd3
  } sq_state_t;
endpackage

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import pic_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_req_i,
  output logic busy_o,
  output logic lead_o,
  output logic trail_o,
  output logic done_o
);
  localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] G_LAST = CW'(GAP_CYC - 1);

  sq_state_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (ack_req_i) begin
          st  <= SQ_P1;
          cnt <= '0;
        end
        SQ_P1: if (cnt == P_LAST) begin
          st  <= SQ_GAP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        SQ_GAP: if (cnt == G_LAST) begin
          st  <= SQ_P2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == P_LAST) begin
          st  <= SQ_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign busy_o  = (st != SQ_IDLE);
  assign lead_o  = (st == SQ_P1) && (cnt == '0);
  assign trail_o = (st == SQ_P1) && (cnt == P_LAST);
  assign done_o  = (st == SQ_P2) && (cnt == P_LAST);
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_i,
  input  logic [N_LINES-1:0] lvl_i,
  input  logic               take_i,
  input  logic               eoi_i,
  input  logic               clr_i,
  input  logic [IW-1:0]      clr_idx_i,
  output logic               pend_o,
  output logic [IW-1:0]      idx_o,
  output logic [N_LINES-1:0] irr_o,
  output logic [N_LINES-1:0] isr_o
);
  logic [N_LINES-1:0] irr_q, isr_q, line_q;
  logic [N_LINES-1:0] allow, cand, gsel, eoi_sel, clr_sel, set_sel;

  // a request may win only when no in-service bit sits at its own or a higher priority
  for (genvar b = 0; b < N_LINES; b++) begin : g_allow
    assign allow[b] = ~|isr_q[b:0];
  end

  assign cand    = irr_q & allow;
  assign gsel    = cand & (~cand + 1'b1);
  assign pend_o  = |cand;
  assign eoi_sel = eoi_i ? (isr_q & (~isr_q + 1'b1)) : '0;
  assign clr_sel = clr_i ? (N_LINES'(1) << clr_idx_i) : '0;
  assign set_sel = take_i ? gsel : '0;

  always_comb begin
    idx_o = '0;
    for (int b = 0; b < N_LINES; b++) begin
      if (gsel[b]) idx_o = IW'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      isr_q  <= '0;
      line_q <= '1;
    end else begin
      line_q <= line_i;
      isr_q  <= (isr_q & ~eoi_sel & ~clr_sel) | set_sel;
      for (int b = 0; b < N_LINES; b++) begin
        if (set_sel[b])       irr_q[b] <= 1'b0;
        else if (lvl_i[b])    irr_q[b] <= line_i[b];
        else if (!line_i[b])  irr_q[b] <= 1'b0;
        else if (!line_q[b])  irr_q[b] <= 1'b1;
      end
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack #(
  parameter int N_LINES   = 8,
  parameter int VEC_W     = 8,
  parameter int PULSE_CYC = 2,
  parameter int GAP_CYC   = 1,
  localparam int IW = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_m_i,
  input  logic [N_LINES-1:0] irq_s_i,
  input  logic               ack_req_i,
  input  logic               eoi_m_i,
  input  logic               eoi_s_i,
  input  logic [VEC_W-IW-1:0] base_m_hi_i,
  input  logic [VEC_W-IW-1:0] base_s_hi_i,
  input  logic               casc_en_i,
  input  logic [IW-1:0]      slave_id_i,
  input  logic               aeoi_i,
  output logic               intr_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o,
  output logic [IW-1:0]      cas_o,
  output logic               cas_act_o,
  output logic [N_LINES-1:0] irr_m_o,
  output logic [N_LINES-1:0] isr_m_o,
  output logic [N_LINES-1:0] irr_s_o,
  output logic [N_LINES-1:0] isr_s_o
);
  localparam logic [IW-1:0] SPUR_IDX = '1;

  logic busy, lead, trail, done;
  logic m_pend, s_pend, to_slave, match;
  logic [IW-1:0] m_idx, s_idx, m_code, s_code;
  logic [N_LINES-1:0] slv_bit, m_lines;
  logic h_m_hit, h_s_hit, h_slv;
  logic [IW-1:0] h_m_idx, h_s_idx;
  logic m_clr, s_clr;
  logic [VEC_W-1:0] vec_next;

  pic_ack_seq #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst(rst), .ack_req_i(ack_req_i),
    .busy_o(busy), .lead_o(lead), .trail_o(trail), .done_o(done)
  );

  // slave pending state replaces the external line at its attachment point
  assign slv_bit  = casc_en_i ? (N_LINES'(1) << slave_id_i) : '0;
  assign m_lines  = (irq_m_i & ~slv_bit) | (s_pend ? slv_bit : '0);
  assign to_slave = casc_en_i && m_pend && (m_idx == slave_id_i);
  assign m_clr    = done && aeoi_i && h_m_hit;
  assign s_clr    = done && aeoi_i && h_slv && h_s_hit;

  pic_core #(.N_LINES(N_LINES)) u_master (
    .clk(clk), .rst(rst), .line_i(m_lines), .lvl_i(slv_bit),
    .take_i(lead), .eoi_i(eoi_m_i), .clr_i(m_clr), .clr_idx_i(h_m_idx),
    .pend_o(m_pend), .idx_o(m_idx), .irr_o(irr_m_o), .isr_o(isr_m_o)
  );

  pic_core #(.N_LINES(N_LINES)) u_slave (
    .clk(clk), .rst(rst), .line_i(irq_s_i), .lvl_i({N_LINES{1'b0}}),
    .take_i(lead && to_slave), .eoi_i(eoi_s_i), .clr_i(s_clr), .clr_idx_i(h_s_idx),
    .pend_o(s_pend), .idx_o(s_idx), .irr_o(irr_s_o), .isr_o(isr_s_o)
  );

  assign m_code   = h_m_hit ? h_m_idx : SPUR_IDX;
  assign s_code   = h_s_hit ? h_s_idx : SPUR_IDX;
  assign match    = cas_act_o && (cas_o == slave_id_i);
  assign vec_next = match ? {base_s_hi_i, s_code} : {base_m_hi_i, m_code};

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_o    <= 1'b0;
      vec_o     <= '0;
      vec_vld_o <= 1'b0;
      cas_o     <= '0;
      cas_act_o <= 1'b0;
      h_m_hit   <= 1'b0;
      h_s_hit   <= 1'b0;
      h_slv     <= 1'b0;
      h_m_idx   <= '0;
      h_s_idx   <= '0;
    end else begin
      intr_o    <= m_pend && !busy;
      vec_vld_o <= done;
      if (lead) begin
        h_m_hit <= m_pend;
        h_m_idx <= m_idx;
        h_s_hit <= s_pend;
        h_s_idx <= s_idx;
        h_slv   <= to_slave;
      end
      if (trail) begin
        cas_act_o <= lead ? to_slave : h_slv;
        cas_o     <= lead ? m_idx : h_m_idx;
      end else if (done) begin
        cas_act_o <= 1'b0;
      end
      if (done) vec_o <= vec_next;
    end
  end
endmodule

// File: rtl/pic_cascade_ack_chk.sv
module pic_cascade_ack_chk #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_s_i,
  input logic [N_LINES-1:0] irr_s_o,
  input logic [N_LINES-1:0] isr_m_o,
  input logic [N_LINES-1:0] isr_s_o,
  input logic               vec_vld_o,
  input logic               cas_act_o,
  input logic [IW-1:0]      cas_o,
  input logic               intr_o,
  input logic               casc_en_i
);
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |=> !vec_vld_o); // R1
  AST_IRR_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    ((irr_s_o & ~$past(irr_s_o) & ~$past(irq_s_i)) == '0)); // R2
  AST_ISR_M_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_m_o) <= $countones($past(isr_m_o)) + 1); // R3
  AST_ISR_S_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_s_o) <= $countones($past(isr_s_o)) + 1); // R3
  AST_INTR_LOW_AT_CAS: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_act_o) |-> !intr_o); // R4
  AST_CAS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    cas_act_o |-> casc_en_i); // R5
  AST_CAS_DROP_AT_VEC: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> !cas_act_o); // R5
  AST_CAS_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cas_act_o && $past(cas_act_o)) |-> $stable(cas_o)); // R5
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_s_i(irq_s_i), .irr_s_o(irr_s_o),
  .isr_m_o(isr_m_o), .isr_s_o(isr_s_o), .vec_vld_o(vec_vld_o),
  .cas_act_o(cas_act_o), .cas_o(cas_o), .intr_o(intr_o), .casc_en_i(casc_en_i)
);

// File: tb/pic_cascade_ack_bench.sv
`timescale 1ns/1ps
module pic_cascade_ack_bench;
  localparam int P = 2;
  localparam int G = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_m_i = '0, irq_s_i = '0;
  logic ack_req_i = 0, eoi_m_i = 0, eoi_s_i = 0, casc_en_i = 0, aeoi_i = 0;
  logic [4:0] base_m_hi_i = 5'b00001, base_s_hi_i = 5'b01110;
  logic [2:0] slave_id_i = 3'd2;
  logic intr_o, vec_vld_o, cas_act_o;
  logic [7:0] vec_o, irr_m_o, isr_m_o, irr_s_o, isr_s_o;
  logic [2:0] cas_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  pic_cascade_ack #(.PULSE_CYC(P), .GAP_CYC(G)) u_pic_cascade_ack (
    .clk(clk), .rst(rst), .irq_m_i(irq_m_i), .irq_s_i(irq_s_i),
    .ack_req_i(ack_req_i), .eoi_m_i(eoi_m_i), .eoi_s_i(eoi_s_i),
    .base_m_hi_i(base_m_hi_i), .base_s_hi_i(base_s_hi_i),
    .casc_en_i(casc_en_i), .slave_id_i(slave_id_i), .aeoi_i(aeoi_i),
    .intr_o(intr_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o), .cas_o(cas_o),
    .cas_act_o(cas_act_o), .irr_m_o(irr_m_o), .isr_m_o(isr_m_o),
    .irr_s_o(irr_s_o), .isr_s_o(isr_s_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [7:0] m_irr, m_isr, s_irr, s_isr, m_q, s_q;
  int st, cnt, hm_idx, hs_idx;
  logic hm_hit, hs_hit, h_slv;
  logic e_intr, e_vld, e_cas_act;
  logic [2:0] e_cas;
  logic [7:0] e_vec;

  function automatic int pick(input logic [7:0] irr, input logic [7:0] isr);
    for (int b = 0; b < 8; b++) begin
      if (isr[b]) return -1;
      if (irr[b]) return b;
    end
    return -1;
  endfunction

  function automatic logic [7:0] drop_first(input logic [7:0] v);
    for (int b = 0; b < 8; b++) if (v[b]) begin v[b] = 1'b0; return v; end
    return v;
  endfunction

  always @(posedge clk) begin
    int mg, sg, hm_c, hs_c;
    logic s_pnd, lead, trail, fin, tosl, match;
    logic [7:0] slvbit, ml, nm_irr, ns_irr, nm_isr, ns_isr;
    if (rst) begin
      m_irr = 0; m_isr = 0; s_irr = 0; s_isr = 0; m_q = '1; s_q = '1;
      st = 0; cnt = 0; hm_idx = 0; hs_idx = 0; hm_hit = 0; hs_hit = 0; h_slv = 0;
      e_intr = 0; e_vld = 0; e_cas_act = 0; e_cas = 0; e_vec = 0;
    end else begin
      sg = pick(s_irr, s_isr);
      s_pnd = (sg >= 0);
      slvbit = casc_en_i ? (8'd1 << slave_id_i) : 8'd0;
      ml = (irq_m_i & ~slvbit) | (s_pnd ? slvbit : 8'd0);
      mg = pick(m_irr, m_isr);
      lead = (st == 1 && cnt == 0);
      trail = (st == 1 && cnt == P - 1);
      fin = (st == 3 && cnt == P - 1);
      tosl = casc_en_i && (mg >= 0) && (mg == int'(slave_id_i));
      e_intr = (mg >= 0) && (st == 0);
      if (fin) begin
        match = e_cas_act && (e_cas == slave_id_i);
        hm_c = hm_hit ? hm_idx : 7;
        hs_c = hs_hit ? hs_idx : 7;
        e_vec = match ? {base_s_hi_i, 3'(hs_c)} : {base_m_hi_i, 3'(hm_c)};
      end
      e_vld = fin;
      if (trail) begin
        e_cas_act = lead ? tosl : h_slv;
        e_cas = lead ? 3'((mg < 0) ? 0 : mg) : 3'(hm_idx);
      end else if (fin) e_cas_act = 0;
      nm_isr = eoi_m_i ? drop_first(m_isr) : m_isr;
      ns_isr = eoi_s_i ? drop_first(s_isr) : s_isr;
      if (fin && aeoi_i && hm_hit) nm_isr[hm_idx] = 1'b0;
      if (fin && aeoi_i && h_slv && hs_hit) ns_isr[hs_idx] = 1'b0;
      if (lead && mg >= 0) nm_isr[mg] = 1'b1;
      if (lead && tosl && sg >= 0) ns_isr[sg] = 1'b1;
      for (int b = 0; b < 8; b++) begin
        if (lead && mg == b) nm_irr[b] = 0;
        else if (slvbit[b]) nm_irr[b] = s_pnd;
        else if (!ml[b]) nm_irr[b] = 0;
        else if (!m_q[b]) nm_irr[b] = 1;
        else nm_irr[b] = m_irr[b];
        if (lead && tosl && sg == b) ns_irr[b] = 0;
        else if (!irq_s_i[b]) ns_irr[b] = 0;
        else if (!s_q[b]) ns_irr[b] = 1;
        else ns_irr[b] = s_irr[b];
      end
      if (lead) begin
        hm_hit = (mg >= 0); hm_idx = (mg < 0) ? 0 : mg;
        hs_hit = s_pnd;     hs_idx = (sg < 0) ? 0 : sg;
        h_slv = tosl;
      end
      m_q = ml; s_q = irq_s_i;
      m_irr = nm_irr; s_irr = ns_irr; m_isr = nm_isr; s_isr = ns_isr;
      case (st)
        0: if (ack_req_i) begin st = 1; cnt = 0; end
        1: if (cnt == P - 1) begin st = 2; cnt = 0; end else cnt++;
        2: if (cnt == G - 1) begin st = 3; cnt = 0; end else cnt++;
        default: if (cnt == P - 1) begin st = 0; cnt = 0; end else cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R4 intr model", intr_o, e_intr);
      chk("R1 vld model", vec_vld_o, e_vld);
      chk("R7 vec model", vec_o, e_vec);
      chk("R5 cas_act model", cas_act_o, e_cas_act);
      chk("R5 cas model", cas_o, e_cas);
      chk("R2 irr_m model", irr_m_o, m_irr);
      chk("R3 isr_m model", isr_m_o, m_isr);
      chk("R6 irr_s model", irr_s_o, s_irr);
      chk("R9 isr_s model", isr_s_o, s_isr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic ack_pulse();
    ack_req_i = 1; step(1); ack_req_i = 0;
  endtask

  task automatic wait_vld(output logic [7:0] v, output logic seen, output logic [2:0] code,
                          output int cyc);
    v = 0; seen = 0; code = 0; cyc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cas_act_o) begin seen = 1; code = cas_o; end
      if (vec_vld_o) begin v = vec_o; cyc = i + 1; return; end
    end
    chk("R1 vector timeout", 0, 1);
  endtask

  initial begin
    logic [7:0] v; logic seen; logic [2:0] code; int cyc, nvld;
    irq_m_i[0] = 1;
    step(4);
    rst = 0;
    cmp_on = 1;
    #1;
    chk("R12 reset isr_m", isr_m_o, 0);
    chk("R12 reset vld", vec_vld_o, 0);
    chk("R12 reset cas_act", cas_act_o, 0);
    step(3);
    chk("R2 high at reset not latched", irr_m_o[0], 0);
    irq_m_i[0] = 0;
    step(2);

    // plain master request
    irq_m_i[3] = 1; step(2);
    chk("R2 irr set on rise", irr_m_o[3], 1);
    chk("R4 intr raised", intr_o, 1);
    ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R1 vector latency", cyc, 2 * P + G + 1);
    chk("R7 master vector", v, {5'b00001, 3'd3});
    chk("R5 no cascade code", seen, 0);
    chk("R3 isr set", isr_m_o, 8'b0000_1000);
    step(3);
    chk("R9 isr held without aeoi", isr_m_o, 8'b0000_1000);
    eoi_m_i = 1; step(1); eoi_m_i = 0; #1;
    chk("R10 eoi clears", isr_m_o, 0);
    irq_m_i[3] = 0; step(2);

    // priority and nesting
    irq_m_i[5] = 1; irq_m_i[1] = 1; step(2);
    ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R3 priority winner", v[2:0], 3'd1);
    step(2);
    chk("R4 intr blocked by isr", intr_o, 0);
    eoi_m_i = 1; step(1); eoi_m_i = 0; step(2);
    chk("R10 eoi unblocks", intr_o, 1);
    ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R3 second winner", v[2:0], 3'd5);
    eoi_m_i = 1; step(1); eoi_m_i = 0;
    irq_m_i = 0; step(2);

    // cascaded slave
    casc_en_i = 1; slave_id_i = 3'd2; step(1);
    irq_s_i[4] = 1; step(3);
    chk("R6 slave raises intr", intr_o, 1);
    ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R5 cascade active", seen, 1);
    chk("R5 cascade code", code, 3'd2);
    chk("R6 slave vector", v, {5'b01110, 3'd4});
    chk("R3 slave isr", isr_s_o, 8'b0001_0000);
    eoi_s_i = 1; eoi_m_i = 1; step(1); eoi_s_i = 0; eoi_m_i = 0;
    irq_s_i = 0; step(2);

    // spurious
    irq_m_i[6] = 1; step(2);
    irq_m_i[6] = 0; ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R8 spurious vector", v, {5'b00001, 3'd7});
    chk("R8 no isr on spurious", isr_m_o, 0);
    step(2);

    // automatic end of interrupt
    aeoi_i = 1;
    irq_m_i[0] = 1; step(2);
    ack_pulse();
    wait_vld(v, seen, code, cyc);
    chk("R7 aeoi vector", v, {5'b00001, 3'd0});
    chk("R9 aeoi cleared", isr_m_o, 0);
    irq_m_i[0] = 0; step(2);

    // acknowledge while busy
    irq_m_i[4] = 1; step(2);
    ack_pulse(); step(1); ack_pulse();
    nvld = 0;
    for (int i = 0; i < 14; i++) begin @(negedge clk); if (vec_vld_o) nvld++; end
    chk("R11 busy ack ignored", nvld, 1);
    irq_m_i = 0; aeoi_i = 0; step(1);

    // randomised traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) irq_m_i = 8'($urandom);
      if ($urandom % 4 == 0) irq_s_i = 8'($urandom);
      ack_req_i = ($urandom % 6 == 0);
      eoi_m_i = ($urandom % 5 == 0);
      eoi_s_i = ($urandom % 5 == 0);
      if ($urandom % 50 == 0) aeoi_i = ~aeoi_i;
      step(1);
    end
    ack_req_i = 0; eoi_m_i = 0; eoi_s_i = 0;
    step(10);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule